// File: doc/BRIEF.md
# Timer and External-Interrupt Control Register

This block is an eight-bit special-function register. It holds the run-enable bits for two timers, the overflow flags of those timers, and the trigger-type and pending-flag logic for two active-low external interrupt pins. The timers, the interrupt prioritiser and the processor core sit outside it. The block receives the timer overflow pulses and the per-source acknowledge pulses that the interrupt controller produces when it vectors to a handler. It drives the run enables and one pending-request line for each flag.

Software reaches the register over the special-function bus. A byte write or a byte read uses the register address 0x88. A single-bit write uses a bit address in the range 0x88 to 0x8F, where bit address 0x88+n selects bit n. The external pins are sampled only when the machine-cycle strobe is high. The trigger-type bit of each pin picks one of two behaviours. In low-level mode the pending flag is rewritten on every sample. In falling-edge mode the flag latches when a sample that was high is followed by a sample that is low.

Top module: `tcon_ctl`

## Requirements
- R1: Reset is synchronous and active low. It clears every register bit, so `reg_q` reads 0x00 and all run and request outputs are low. Reset also loads each pin's stored sample with the high state, so a pin that is low at the first strobe after reset counts as a falling edge in edge mode.
- R2: A byte write with `sfr_addr` equal to 0x88 loads all eight bits from `sfr_wdata`. A byte write to any other address changes nothing. `sfr_rdata` shows the register contents while `sfr_addr` is 0x88 and shows 0x00 otherwise.
- R3: A bit write to bit address 0x88+n (n from 0 to 7) sets or clears only bit n, using `sfr_bit_val`. A bit address outside 0x88 to 0x8F changes nothing.
- R4: The register bit layout is, from bit 7 down to bit 0: timer-1 flag, timer-1 run, timer-0 flag, timer-0 run, pin-1 flag, pin-1 type, pin-0 flag, pin-0 type. `run_en[1]` follows bit 6 and `run_en[0]` follows bit 4.
- R5: A pulse on `tmr_ovf[i]` sets the flag of timer i on the next clock edge. A pulse on `ack_tmr[i]` clears that flag. When an overflow and an acknowledge arrive in the same cycle, the flag ends up set.
- R6: When a pin's type bit is 1 (edge mode), its flag is set at a strobe that samples the pin low, provided the previous strobe sampled it high. A low pin without a strobe sets nothing, and a pin that stays low does not set the flag again.
- R7: In edge mode, `ack_xint[i]` clears the flag of pin i. A new edge that arrives in the same cycle as the acknowledge wins, and the flag stays set.
- R8: When a pin's type bit is 0 (level mode), each strobe writes the inverse of the pin into its flag. Between strobes the flag holds its value.
- R9: A hardware set in the same cycle as a software write of 0 to that flag leaves the flag at 1. A hardware set here means a timer overflow, a detected edge, or a level-mode sample of a low pin.
- R10: `tmr_irq` equals {bit 7, bit 5} and `xint_irq` equals {bit 3, bit 1} of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_stb | input | 1 | Machine-cycle strobe; the pins are sampled while it is high |
| xint_n | input | 2 | Raw active-low external interrupt pins |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ack_tmr | input | 2 | Timer interrupt acknowledge pulses |
| ack_xint | input | 2 | External interrupt acknowledge pulses |
| sfr_addr | input | 8 | Byte address for reads and byte writes |
| sfr_wdata | input | 8 | Byte write data |
| sfr_we | input | 1 | Byte write enable |
| sfr_bit_we | input | 1 | Single-bit write enable |
| sfr_bit_addr | input | 8 | Bit address for single-bit writes |
| sfr_bit_val | input | 1 | Value for single-bit writes |
| sfr_rdata | output | 8 | Read data; 0x00 unless `sfr_addr` is 0x88 |
| reg_q | output | 8 | Register contents |
| run_en | output | 2 | Timer run enables |
| tmr_irq | output | 2 | Timer pending requests |
| xint_irq | output | 2 | External pin pending requests |

## Verification
Every flag and control bit is visible on `reg_q` and on a request or run line one clock after the event that changes it, so a wrong next-state decision shows at the ports on the following edge. The stored pin sample is the one piece of state that `reg_q` does not show. An error in it surfaces only at the next strobe in edge mode, either as a spurious set or as a missing set. The bench therefore reaches it through strobes that follow a sample taken several cycles earlier.

// File: rtl/tcon_pkg.sv
package tcon_pkg;
    localparam int NUM_TMR  = 2;
    localparam int NUM_XINT = 2;
    localparam int REG_W    = 8;

    typedef struct packed {
        logic run;
        logic flag;
    } tmr_st_t;

    typedef struct packed {
        logic mode;   // 1 = falling edge, 0 = low level
        logic flag;
        logic smp;    // pin value at the previous strobe
    } xint_st_t;
endpackage

// File: rtl/tcon_bus_dec.sv
module tcon_bus_dec #(
    parameter int AW = 8,
    parameter logic [AW-1:0] ADDR = 8'h88,
    parameter int W = 8
) (
    input  logic [AW-1:0] sfr_addr,
    input  logic [W-1:0]  sfr_wdata,
    input  logic          sfr_we,
    input  logic          sfr_bit_we,
    input  logic [AW-1:0] sfr_bit_addr,
    input  logic          sfr_bit_val,
    input  logic [W-1:0]  reg_val,
    output logic [W-1:0]  wr_mask,
    output logic [W-1:0]  wr_val,
    output logic [W-1:0]  rdata
);
    localparam int BW = $clog2(W);

    logic byte_hit;
    logic bit_hit;

    always_comb begin
        byte_hit = sfr_we && (sfr_addr == ADDR);
        bit_hit  = sfr_bit_we && (sfr_bit_addr[AW-1:BW] == ADDR[AW-1:BW]);
        wr_mask  = '0;
        wr_val   = '0;
        if (byte_hit) begin
            wr_mask = '1;
            wr_val  = sfr_wdata;
        end else if (bit_hit) begin
            wr_mask[sfr_bit_addr[BW-1:0]] = 1'b1;
            wr_val  = {W{sfr_bit_val}};
        end
        rdata = (sfr_addr == ADDR) ? reg_val : '0;
    end
endmodule

// File: rtl/tcon_tmr_cell.sv
module tcon_tmr_cell
    import tcon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic ack,
    input  logic run_we,
    input  logic run_wv,
    input  logic flg_we,
    input  logic flg_wv,
    output logic run,
    output logic flag
);
    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run_we) st_d.run = run_wv;
        if (flg_we)   st_d.flag = flg_wv;
        else if (ack) st_d.flag = 1'b0;
        if (ovf)      st_d.flag = 1'b1;  // a new event is never lost
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run  = st_q.run;
    assign flag = st_q.flag;
endmodule

// File: rtl/tcon_xint_cell.sv
module tcon_xint_cell
    import tcon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mc_stb,
    input  logic pin_n,
    input  logic ack,
    input  logic mode_we,
    input  logic mode_wv,
    input  logic flg_we,
    input  logic flg_wv,
    output logic mode,
    output logic flag
);
    xint_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode_we) st_d.mode = mode_wv;
        if (flg_we)   st_d.flag = flg_wv;
        else if (ack) st_d.flag = 1'b0;
        if (mc_stb) begin
            st_d.smp = pin_n;
            if (!st_q.mode)
                st_d.flag = ~pin_n;
            else if (st_q.smp && !pin_n)
                st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mode: 1'b0, flag: 1'b0, smp: 1'b1};
        else        st_q <= st_d;
    end

    assign mode = st_q.mode;
    assign flag = st_q.flag;
endmodule

// File: rtl/tcon_ctl.sv
module tcon_ctl
    import tcon_pkg::*;
#(
    parameter int AW = 8,
    parameter logic [AW-1:0] ADDR = 8'h88
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mc_stb,
    input  logic [NUM_XINT-1:0] xint_n,
    input  logic [NUM_TMR-1:0]  tmr_ovf,
    input  logic [NUM_TMR-1:0]  ack_tmr,
    input  logic [NUM_XINT-1:0] ack_xint,
    input  logic [AW-1:0]       sfr_addr,
    input  logic [REG_W-1:0]    sfr_wdata,
    input  logic                sfr_we,
    input  logic                sfr_bit_we,
    input  logic [AW-1:0]       sfr_bit_addr,
    input  logic                sfr_bit_val,
    output logic [REG_W-1:0]    sfr_rdata,
    output logic [REG_W-1:0]    reg_q,
    output logic [NUM_TMR-1:0]  run_en,
    output logic [NUM_TMR-1:0]  tmr_irq,
    output logic [NUM_XINT-1:0] xint_irq
);
    localparam int TMR_BASE = 2 * NUM_XINT;

    logic [REG_W-1:0] reg_val;
    logic [REG_W-1:0] wr_mask;
    logic [REG_W-1:0] wr_val;

    tcon_bus_dec #(.AW(AW), .ADDR(ADDR), .W(REG_W)) u_dec (
        .sfr_addr     (sfr_addr),
        .sfr_wdata    (sfr_wdata),
        .sfr_we       (sfr_we),
        .sfr_bit_we   (sfr_bit_we),
        .sfr_bit_addr (sfr_bit_addr),
        .sfr_bit_val  (sfr_bit_val),
        .reg_val      (reg_val),
        .wr_mask      (wr_mask),
        .wr_val       (wr_val),
        .rdata        (sfr_rdata)
    );

    for (genvar i = 0; i < NUM_XINT; i++) begin : g_xint
        localparam int MB = 2 * i;
        localparam int FB = 2 * i + 1;
        tcon_xint_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .mc_stb  (mc_stb),
            .pin_n   (xint_n[i]),
            .ack     (ack_xint[i]),
            .mode_we (wr_mask[MB]),
            .mode_wv (wr_val[MB]),
            .flg_we  (wr_mask[FB]),
            .flg_wv  (wr_val[FB]),
            .mode    (reg_val[MB]),
            .flag    (reg_val[FB])
        );
        assign xint_irq[i] = reg_val[FB];
    end

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        localparam int RB = TMR_BASE + 2 * i;
        localparam int FB = TMR_BASE + 2 * i + 1;
        tcon_tmr_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .ovf    (tmr_ovf[i]),
            .ack    (ack_tmr[i]),
            .run_we (wr_mask[RB]),
            .run_wv (wr_val[RB]),
            .flg_we (wr_mask[FB]),
            .flg_wv (wr_val[FB]),
            .run    (reg_val[RB]),
            .flag   (reg_val[FB])
        );
        assign run_en[i]  = reg_val[RB];
        assign tmr_irq[i] = reg_val[FB];
    end

    assign reg_q = reg_val;
endmodule

// File: rtl/tcon_chk.sv
module tcon_chk #(
    parameter int AW = 8,
    parameter logic [AW-1:0] ADDR = 8'h88
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mc_stb,
    input logic [1:0]    xint_n,
    input logic [1:0]    tmr_ovf,
    input logic [1:0]    ack_tmr,
    input logic [1:0]    ack_xint,
    input logic [AW-1:0] sfr_addr,
    input logic [7:0]    sfr_wdata,
    input logic          sfr_we,
    input logic          sfr_bit_we,
    input logic [AW-1:0] sfr_bit_addr,
    input logic          sfr_bit_val,
    input logic [7:0]    sfr_rdata,
    input logic [7:0]    reg_q,
    input logic [1:0]    run_en,
    input logic [1:0]    tmr_irq,
    input logic [1:0]    xint_irq
);
    logic [7:0] hit;
    logic [7:0] hv;
    logic [1:0] smp_q;

    always_comb begin
        for (int k = 0; k < 8; k++) begin
            hit[k] = (sfr_we && sfr_addr == ADDR) ||
                     (sfr_bit_we && sfr_bit_addr == ADDR + AW'(k));
            hv[k]  = (sfr_we && sfr_addr == ADDR) ? sfr_wdata[k] : sfr_bit_val;
        end
    end

    // independent record of the last strobe sample
    always_ff @(posedge clk) begin
        if (!rst_n)      smp_q <= 2'b11;
        else if (mc_stb) smp_q <= xint_n;
    end

    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (reg_q == 8'h00));

    p_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr != ADDR) |-> (sfr_rdata == 8'h00));

    for (genvar i = 0; i < 2; i++) begin : g_a
        localparam int RB = 4 + 2 * i;
        localparam int TB = 5 + 2 * i;
        localparam int MB = 2 * i;
        localparam int XB = 2 * i + 1;

        p_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
            hit[RB] |=> (run_en[i] == $past(hv[RB])));

        p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_ovf[i] |=> tmr_irq[i]);

        p_ack_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_tmr[i] && !tmr_ovf[i] && !hit[TB]) |=> !reg_q[TB]);

        p_edge_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_q[MB] && mc_stb && smp_q[i] && !xint_n[i]) |=> xint_irq[i]);

        p_edge_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_q[MB] && ack_xint[i] && !mc_stb && !hit[XB]) |=> !xint_irq[i]);

        p_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!reg_q[MB] && mc_stb) |=> (reg_q[XB] == !$past(xint_n[i])));

        p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!reg_q[MB] && !mc_stb && !ack_xint[i] && !hit[XB]) |=> $stable(reg_q[XB]));
    end
endmodule

bind tcon_ctl tcon_chk #(.AW(AW), .ADDR(ADDR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mc_stb       (mc_stb),
    .xint_n       (xint_n),
    .tmr_ovf      (tmr_ovf),
    .ack_tmr      (ack_tmr),
    .ack_xint     (ack_xint),
    .sfr_addr     (sfr_addr),
    .sfr_wdata    (sfr_wdata),
    .sfr_we       (sfr_we),
    .sfr_bit_we   (sfr_bit_we),
    .sfr_bit_addr (sfr_bit_addr),
    .sfr_bit_val  (sfr_bit_val),
    .sfr_rdata    (sfr_rdata),
    .reg_q        (reg_q),
    .run_en       (run_en),
    .tmr_irq      (tmr_irq),
    .xint_irq     (xint_irq)
);

// File: tb/tb_tcon_ctl.sv
module tb_tcon_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_stb = 1'b0;
    logic [1:0] xint_n = 2'b11;
    logic [1:0] tmr_ovf = '0, ack_tmr = '0, ack_xint = '0;
    logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00, sfr_bit_addr = 8'h00;
    logic       sfr_we = 1'b0, sfr_bit_we = 1'b0, sfr_bit_val = 1'b0;
    logic [7:0] sfr_rdata, reg_q;
    logic [1:0] run_en, tmr_irq, xint_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    tcon_ctl dut (
        .clk(clk), .rst_n(rst_n), .mc_stb(mc_stb), .xint_n(xint_n),
        .tmr_ovf(tmr_ovf), .ack_tmr(ack_tmr), .ack_xint(ack_xint),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_we(sfr_we),
        .sfr_bit_we(sfr_bit_we), .sfr_bit_addr(sfr_bit_addr),
        .sfr_bit_val(sfr_bit_val), .sfr_rdata(sfr_rdata), .reg_q(reg_q),
        .run_en(run_en), .tmr_irq(tmr_irq), .xint_irq(xint_irq)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       stb;
        logic [1:0] pin;
        logic [1:0] ovf;
        logic [1:0] akt;
        logic [1:0] akx;
        logic       we;
        logic [7:0] wd;
        logic       bwe;
        logic [2:0] bidx;
        logic       bval;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 29;
    // req, stb, pin, ovf, akt, akx, we, wd, bwe, bidx, bval, exp
    localparam vec_t VEC [NV] = '{
        '{4'd2, 1'b0, 2'b11, 2'b00, 2'b00, 2'b00, 1'b1, 8'h55, 1'b0, 3'd0, 1'b0, 8'h55}, // R2 byte write
        '{4'd5, 1'b0, 2'b11, 2'b01, 2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h75}, // R5 ovf0
        '{4'd5, 1'b0, 2'b11, 2'b10, 2'b01, 2'b00, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'hD5}, // R5 ovf1, ack0
        '{4'd5, 1'b0, 2'b11, 2'b00, 2'b10, 2'b00, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h55}, // R5 ack1
        '{4'd5, 1'b0, 2'b11, 2'b10, 2'b10, 2'b00, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'hD5}, // R5 set beats ack
        '{4'd5, 1'b0, 2'b11, 2'b00, 2'b10, 2'b00, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h55}, // R5 ack1
        '{4'd6, 1'b1, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h55}, // R6 high sample
        '{4'd6, 1'b0, 2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h55}, // R6 low, no strobe
        '{4'd6, 1'b1, 2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h57}, // R6 edge pin0
        '{4'd6, 1'b1, 2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h57}, // R6 latched
        '{4'd7, 1'b0, 2'b10, 2'b00, 2'b00, 2'b01, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h55}, // R7 ack pin0
        '{4'd6, 1'b1, 2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h55}, // R6 still low
        '{4'd6, 1'b1, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h55}, // R6 back high
        '{4'd6, 1'b1, 2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h5D}, // R6 edge pin1
        '{4'd7, 1'b1, 2'b11, 2'b00, 2'b00, 2'b10, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h55}, // R7 ack pin1
        '{4'd7, 1'b1, 2'b01, 2'b00, 2'b00, 2'b10, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h5D}, // R7 edge beats ack
        '{4'd7, 1'b0, 2'b01, 2'b00, 2'b00, 2'b10, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h55}, // R7 ack pin1
        '{4'd8, 1'b0, 2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 8'h50, 1'b0, 3'd0, 1'b0, 8'h50}, // R8 level mode
        '{4'd8, 1'b1, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h5A}, // R8 both low
        '{4'd8, 1'b0, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h5A}, // R8 hold
        '{4'd8, 1'b1, 2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h52}, // R8 follow
        '{4'd8, 1'b1, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h50}, // R8 both high
        '{4'd9, 1'b0, 2'b11, 2'b01, 2'b00, 2'b00, 1'b1, 8'h00, 1'b0, 3'd0, 1'b0, 8'h20}, // R9 ovf over write
        '{4'd3, 1'b0, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0, 8'h00, 1'b1, 3'd4, 1'b1, 8'h30}, // R3 set bit4
        '{4'd3, 1'b0, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0, 8'h00, 1'b1, 3'd5, 1'b0, 8'h10}, // R3 clear bit5
        '{4'd3, 1'b0, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0, 8'h00, 1'b1, 3'd7, 1'b1, 8'h90}, // R3 set bit7
        '{4'd9, 1'b0, 2'b11, 2'b10, 2'b00, 2'b00, 1'b0, 8'h00, 1'b1, 3'd7, 1'b0, 8'h90}, // R9 bit write lost
        '{4'd2, 1'b0, 2'b11, 2'b00, 2'b00, 2'b00, 1'b1, 8'h05, 1'b0, 3'd0, 1'b0, 8'h05}, // R2 edge modes
        '{4'd9, 1'b1, 2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 8'h00, 1'b1, 3'd1, 1'b0, 8'h07}  // R9 edge over write
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic clear_pulses();
        mc_stb = 1'b0; tmr_ovf = '0; ack_tmr = '0; ack_xint = '0;
        sfr_we = 1'b0; sfr_bit_we = 1'b0;
    endtask

    task automatic byte_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        @(negedge clk);
        clear_pulses();
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: state during reset
        chk("R1 reg", reg_q, 8'h00);
        sfr_addr = 8'h88;
        #1 chk("R1 rdata", sfr_rdata, 8'h00);
        chk("R1 outs", {run_en, tmr_irq, xint_irq}, 8'h00);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            mc_stb = VEC[v].stb; xint_n = VEC[v].pin; tmr_ovf = VEC[v].ovf;
            ack_tmr = VEC[v].akt; ack_xint = VEC[v].akx;
            sfr_addr = 8'h88; sfr_we = VEC[v].we; sfr_wdata = VEC[v].wd;
            sfr_bit_we = VEC[v].bwe; sfr_bit_addr = 8'h88 + {5'd0, VEC[v].bidx};
            sfr_bit_val = VEC[v].bval;
            @(negedge clk);
            clear_pulses();
            chk($sformatf("R%0d vec%0d reg", VEC[v].req, v), reg_q, VEC[v].exp);
            // R10: request lines mirror the flags
            chk($sformatf("R10 vec%0d irq", v), {4'd0, tmr_irq, xint_irq},
                {4'd0, VEC[v].exp[7], VEC[v].exp[5], VEC[v].exp[3], VEC[v].exp[1]});
        end

        // R2: other address ignored, reads zero there
        byte_wr(8'h89, 8'hFF);
        chk("R2 wrong addr write", reg_q, 8'h07);
        sfr_addr = 8'h89;
        #1 chk("R2 rdata other addr", sfr_rdata, 8'h00);
        sfr_addr = 8'h88;
        #1 chk("R2 rdata own addr", sfr_rdata, 8'h07);

        // R3: bit address outside range ignored
        @(negedge clk);
        sfr_bit_we = 1'b1; sfr_bit_addr = 8'h90; sfr_bit_val = 1'b1;
        @(negedge clk);
        clear_pulses();
        chk("R3 out of range bit", reg_q, 8'h07);

        // R4: run enables
        byte_wr(8'h88, 8'h40);
        chk("R4 run1", {6'd0, run_en}, 8'h02);
        byte_wr(8'h88, 8'h10);
        chk("R4 run0", {6'd0, run_en}, 8'h01);

        // R1: sample register resets high
        @(negedge clk);
        rst_n = 1'b0; xint_n = 2'b10;
        repeat (3) @(negedge clk);
        chk("R1 reg after reset", reg_q, 8'h00);
        rst_n = 1'b1;
        byte_wr(8'h88, 8'h01);
        chk("R1 edge mode set", reg_q, 8'h01);
        @(negedge clk);
        mc_stb = 1'b1;
        @(negedge clk);
        clear_pulses();
        chk("R1 first low sample is edge", reg_q, 8'h03);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule